// File: doc/BRIEF.md
# Time-Based Link Analysis Counter

This block measures one chosen link statistic over a programmed window and keeps the total in a 64-bit result. The statistic is one of three kinds. It can be the raw number of clock cycles. It can be the number of cycles the link spends in one power or recovery state, taken from a state code that the link logic drives. It can be the transmit or receive payload volume, counted from one pulse per 16-byte unit.

Software writes a single control word. That word names the statistic, chooses a window length and starts the run. The window is either a preset duration or manual. A preset duration is turned into a cycle count from a clock-frequency parameter, and a divider parameter shortens it for simulation. A manual window lasts until software clears the run bit. Starting a run clears the result. When a preset window ends, the run bit clears itself and the result stays readable as two 32-bit halves. The two halves are read straight from the live counter and are not captured together.

Top module: `link_stat_counter`

## Requirements
- R1: After reset, the control word at address 0x10 and both result halves at 0x14 and 0x18 read 0.
- R2: A write to 0x10 sets the report code from data bits 31:24, the duration code from bits 15:8 and the run bit from bit 0. Reading 0x10 returns these three fields in the same positions, and every other bit reads 0.
- R3: A write that sets the run bit while no run is active starts a measurement. The result becomes 0 at that clock edge, and counting begins on the following edge.
- R4: Report code 0x00 adds one on every counted edge. Report codes 0x01 to 0x09 add one on each counted edge at which the 4-bit link_state input equals the code. The state encoding is 1 TX L0s, 2 RX L0s, 3 L0, 4 L1, 5 L1.1, 6 L1.2, 7 recovery, 8 both directions in L0s, 9 L1 auxiliary, and 0 any other state.
- R5: Report codes 0x20 to 0x23 add one on each counted edge at which payload_vld bit (code minus 0x20) is high. The bits are 0 TX PCIe, 1 RX PCIe, 2 TX CCIX and 3 RX CCIX, and each pulse stands for one 16-byte unit.
- R6: With duration code 0x00 the run continues until a write to 0x10 clears bit 0. No edge that carries a control write adds to the result, and after the stop the result holds.
- R7: The preset duration codes 0x01, 0x02, 0x03, 0x04, 0x05 and 0x06 stand for 1, 10, 100, 1000, 2000 and 4000 ms. Such a window lasts N = CLK_KHZ*ms/TIME_DIV counted edges. Code 0xFF lasts N = CLK_KHZ*4/(1000*TIME_DIV) edges. Any N that comes out as 0 becomes 1. After the Nth counted edge the run bit reads 0 and the result holds.
- R8: Address 0x14 returns result bits 31:0 and address 0x18 returns bits 63:32, both taken combinationally from the live counter. Any other read address returns 0.
- R9: An undefined report code (0x0A to 0x1F or 0x24 to 0xFF) or an undefined duration code (0x07 to 0xFE) keeps the result at 0 after a start. The run bit stays 1 until it is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Read data, combinational |
| link_state | input | 4 | Current link state code |
| payload_vld | input | 4 | One pulse per 16-byte payload unit, per direction and protocol |

## Verification
The bench checks that the preset window closes on exactly the Nth edge, using the shortest and two longer windows. A timer that is off by one leaves a result of N-1 or N+1, or leaves the run bit set one cycle too long. It starts a new run after a finished one with an undefined report code. A design that forgets to clear, or that counts undefined codes, then shows a non-zero result. Manual windows test that the stop write's edge is not counted and that the total holds afterwards. State and payload selection is checked against pattern and held inputs, so a wrong decode or a swapped payload bit gives a different total.

// File: rtl/link_stat_counter.sv
module link_stat_counter #(
  parameter int unsigned CLK_KHZ  = 100000,
  parameter int unsigned TIME_DIV = 1,
  parameter int          AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic [3:0]    link_state,
  input  logic [3:0]    payload_vld
);

  function automatic longint unsigned at_least_one(input longint unsigned v);
    return (v == 0) ? 64'd1 : v;
  endfunction

  localparam longint unsigned KHZ   = longint'(CLK_KHZ);
  localparam longint unsigned DIV   = longint'(TIME_DIV);
  localparam longint unsigned W_4US = at_least_one(KHZ * 4 / (1000 * DIV));
  localparam longint unsigned W_1MS = at_least_one(KHZ * 1 / DIV);
  localparam longint unsigned W_10M = at_least_one(KHZ * 10 / DIV);
  localparam longint unsigned W_100 = at_least_one(KHZ * 100 / DIV);
  localparam longint unsigned W_1S  = at_least_one(KHZ * 1000 / DIV);
  localparam longint unsigned W_2S  = at_least_one(KHZ * 2000 / DIV);
  localparam longint unsigned W_4S  = at_least_one(KHZ * 4000 / DIV);
  localparam int              TW    = $clog2(W_4S + 1);

  localparam logic [AW-1:0] A_CTRL = AW'(8'h10);
  localparam logic [AW-1:0] A_LO   = AW'(8'h14);
  localparam logic [AW-1:0] A_HI   = AW'(8'h18);

  function automatic logic [TW-1:0] win_len(input logic [7:0] code);
    case (code)
      8'h01:   win_len = W_1MS[TW-1:0];
      8'h02:   win_len = W_10M[TW-1:0];
      8'h03:   win_len = W_100[TW-1:0];
      8'h04:   win_len = W_1S[TW-1:0];
      8'h05:   win_len = W_2S[TW-1:0];
      8'h06:   win_len = W_4S[TW-1:0];
      8'hFF:   win_len = W_4US[TW-1:0];
      default: win_len = '0;
    endcase
  endfunction

  logic [7:0]    rep_q, dur_q;
  logic          run_q;
  logic [63:0]   cnt_q;
  logic [TW-1:0] left_q;

  logic ctrl_wr, start, preset, dur_ok, rep_ok, hit;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign start   = ctrl_wr && wr_data[0] && !run_q;
  assign preset  = (win_len(dur_q) != '0);
  assign dur_ok  = (dur_q == 8'h00) || preset;

  always_comb begin
    rep_ok = 1'b0;
    hit    = 1'b0;
    if (rep_q == 8'h00) begin
      rep_ok = 1'b1;
      hit    = 1'b1;
    end else if (rep_q <= 8'h09) begin
      rep_ok = 1'b1;
      hit    = (link_state == rep_q[3:0]);
    end else if (rep_q >= 8'h20 && rep_q <= 8'h23) begin
      rep_ok = 1'b1;
      hit    = payload_vld[rep_q[1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q  <= '0;
      dur_q  <= '0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (ctrl_wr) begin
      rep_q <= wr_data[31:24];
      dur_q <= wr_data[15:8];
      run_q <= wr_data[0];
      if (start) begin
        cnt_q  <= '0;
        left_q <= win_len(wr_data[15:8]);
      end
    end else if (run_q) begin
      if (hit && dur_ok) cnt_q <= cnt_q + 64'd1;
      if (preset) begin
        if (left_q <= TW'(1)) run_q <= 1'b0;
        left_q <= left_q - TW'(1);
      end
    end
  end

  assign rd_data = (rd_addr == A_CTRL) ? {rep_q, 8'h00, dur_q, 7'h00, run_q} :
                   (rd_addr == A_LO)   ? cnt_q[31:0] :
                   (rd_addr == A_HI)   ? cnt_q[63:32] : 32'h0;

  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == 64'd0));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 64'd1));

  a_r9_undefined_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ctrl_wr && (!rep_ok || !dur_ok)) |=> $stable(cnt_q));

  a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && preset) |-> (left_q >= TW'(1) && left_q <= win_len(dur_q)));

endmodule

// File: tb/link_stat_counter_test.sv
module link_stat_counter_test;
  localparam int unsigned KHZ = 100000;
  localparam int unsigned DIV = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h0;
  logic [31:0] wr_data = 32'h0;
  logic [7:0]  rd_addr = 8'h10;
  logic [31:0] rd_data;
  logic [3:0]  link_state = 4'h0;
  logic [3:0]  payload_vld = 4'h0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  link_stat_counter #(.CLK_KHZ(KHZ), .TIME_DIV(DIV), .AW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .link_state(link_state), .payload_vld(payload_vld)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic longint window(input int d);
    longint ms;
    longint n;
    case (d)
      1: ms = 1;  2: ms = 10;  3: ms = 100;
      4: ms = 1000;  5: ms = 2000;  6: ms = 4000;
      default: ms = 0;
    endcase
    if (d == 255) n = longint'(KHZ) * 4 / (1000 * longint'(DIV));
    else if (ms != 0) n = longint'(KHZ) * ms / longint'(DIV);
    else return 0;
    return (n == 0) ? 1 : n;
  endfunction

  bit     m_run;
  int     m_rep, m_dur;
  longint m_cnt, m_left;

  function automatic bit m_hit();
    if (m_rep == 0) return 1;
    if (m_rep >= 1 && m_rep <= 9) return int'(link_state) == m_rep;
    if (m_rep >= 32 && m_rep <= 35) return payload_vld[m_rep - 32];
    return 0;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_run = 0; m_rep = 0; m_dur = 0; m_cnt = 0; m_left = 0;
      end else if (wr_en && wr_addr == 8'h10) begin
        if (wr_data[0] && !m_run) begin
          m_cnt = 0;
          m_left = window(int'(wr_data[15:8]));
        end
        m_rep = int'(wr_data[31:24]);
        m_dur = int'(wr_data[15:8]);
        m_run = wr_data[0];
      end else if (m_run) begin
        if (m_hit() && (m_dur == 0 || window(m_dur) != 0)) m_cnt++;
        if (window(m_dur) != 0) begin
          if (m_left <= 1) m_run = 0;
          m_left--;
        end
      end
      #2;
      if (rd_addr == 8'h10)
        check({phase, " model ctrl"}, rd_data, {m_rep[7:0], 8'h00, m_dur[7:0], 7'h00, m_run});
      else if (rd_addr == 8'h14)
        check({phase, " model low"}, rd_data, m_cnt[31:0]);
      else if (rd_addr == 8'h18)
        check({phase, " model high"}, rd_data, m_cnt[63:32]);
      else
        check({phase, " R8 model other"}, rd_data, 32'h0);
    end
  end

  task automatic wr_ctrl(input logic [7:0] rep, input logic [7:0] dur, input bit go);
    wr_en = 1'b1; wr_addr = 8'h10;
    wr_data = {rep, 8'h00, dur, 7'h00, go};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_raw(input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 8'h10; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_pat(input int n);
    for (int i = 0; i < n; i++) begin
      cyc++;
      link_state  = 4'((cyc * 7 + cyc / 3) % 11);
      payload_vld = 4'(cyc ^ (cyc >> 4));
      case (cyc % 4)
        0: rd_addr = 8'h10;  1: rd_addr = 8'h14;
        2: rd_addr = 8'h18;  default: rd_addr = 8'h1C;
      endcase
      @(negedge clk);
    end
  endtask

  task automatic run_hold(input int n, input logic [3:0] ls, input logic [3:0] pv);
    for (int i = 0; i < n; i++) begin
      link_state = ls; payload_vld = pv;
      rd_addr = (i % 2 == 0) ? 8'h14 : 8'h10;
      @(negedge clk);
    end
  endtask

  task automatic peek(input string tag, input logic [7:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    peek("R1 ctrl after reset", 8'h10, 32'h0);
    peek("R1 low after reset", 8'h14, 32'h0);
    peek("R1 high after reset", 8'h18, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R2";
    wr_raw(32'h22FF03FE);
    peek("R2 ctrl fields", 8'h10, 32'h22000300);

    phase = "R7";
    wr_ctrl(8'h00, 8'hFF, 1'b1);
    run_pat(6);
    peek("R7 4us window total", 8'h14, 32'd4);
    peek("R7 4us run bit clear", 8'h10, 32'h0000FF00);
    run_pat(5);
    peek("R7 total holds", 8'h14, 32'd4);

    wr_ctrl(8'h00, 8'h01, 1'b1);
    run_hold(999, 4'h0, 4'h0);
    peek("R7 1ms still running at N-1", 8'h10, 32'h00000101);
    run_hold(3, 4'h0, 4'h0);
    peek("R7 1ms total", 8'h14, 32'd1000);
    peek("R7 1ms run bit clear", 8'h10, 32'h00000100);
    peek("R8 high word zero", 8'h18, 32'h0);
    peek("R8 unmapped address", 8'h1C, 32'h0);

    phase = "R9";
    wr_ctrl(8'h0A, 8'h00, 1'b1);
    run_pat(50);
    peek("R3 R9 cleared by start, undefined report idle", 8'h14, 32'h0);
    peek("R9 run bit stays set", 8'h10, 32'h0A000001);
    wr_ctrl(8'h0A, 8'h00, 1'b0);
    wr_ctrl(8'h00, 8'h07, 1'b1);
    run_pat(30);
    peek("R9 undefined duration idle", 8'h14, 32'h0);
    peek("R9 run bit set for bad duration", 8'h10, 32'h00000701);
    wr_ctrl(8'h00, 8'h07, 1'b0);

    phase = "R6";
    link_state = 4'h4;
    wr_ctrl(8'h04, 8'h00, 1'b1);
    run_hold(20, 4'h4, 4'h0);
    run_hold(10, 4'h5, 4'h0);
    wr_ctrl(8'h04, 8'h00, 1'b0);
    peek("R4 R6 L1 residency total", 8'h14, 32'd20);
    run_hold(10, 4'h4, 4'h0);
    peek("R6 holds after stop", 8'h14, 32'd20);

    phase = "R5";
    wr_ctrl(8'h21, 8'h00, 1'b1);
    run_hold(7, 4'h0, 4'b0010);
    run_hold(5, 4'h0, 4'b1101);
    wr_ctrl(8'h21, 8'h00, 1'b0);
    peek("R5 RX PCIe payload units", 8'h14, 32'd7);

    phase = "R4";
    for (int c = 1; c <= 9; c++) begin
      wr_ctrl(8'(c), 8'h00, 1'b1);
      run_pat(40);
      wr_ctrl(8'(c), 8'h00, 1'b0);
      run_pat(3);
    end
    phase = "R5";
    for (int c = 32; c <= 35; c++) begin
      wr_ctrl(8'(c), 8'h00, 1'b1);
      run_pat(40);
      wr_ctrl(8'(c), 8'h00, 1'b0);
      run_pat(3);
    end
    phase = "R7";
    wr_ctrl(8'h03, 8'h01, 1'b1);
    run_pat(1010);

    wr_ctrl(8'h00, 8'h02, 1'b1);
    run_hold(10005, 4'h0, 4'h0);
    peek("R7 10ms total", 8'h14, 32'd10000);
    peek("R7 10ms run bit clear", 8'h10, 32'h00000200);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule